// File: doc/BRIEF.md
# Fractional-Predivide Programmable Clock Divider

The block derives a slow tick stream from one of three source strobes that share one fast system clock: a reference strobe and two PLL strobes. Each selected strobe passes through a predivider whose ratio is 2, 2.5 or 3. The predivider output then passes through an integer divider with a value from 2 to 127. The overall division is the product of the two ratios. The block gives out a one-cycle tick at each completed division period. It also gives out a clock-like level that toggles on every tick.

Configuration is a 15-bit word, loaded by a one-cycle load pulse, plus a level enable input. The loaded word waits in a pending register and becomes active at the next output tick, so a running period is never cut short. When the block is idle (disabled, or holding an invalid configuration), the pending word takes effect at once. The divide-by-2.5 mode works by alternating 2- and 3-strobe predivider intervals. Because of this, every pair of predivider pulses spans exactly five source strobes.

Top module: `fracdiv_clkgen`

## Requirements
- R1: Word bit 10 clear selects the reference strobe and bit 9 is then ignored. With bit 10 set, bit 9 clear selects PLL strobe A and bit 9 set selects PLL strobe B.
- R2: Word bits 8:7 hold the predivide code: code 1 divides by 2, code 2 by 2.5 and code 3 by 3.
- R3: With code 2 and integer value N, any two consecutive output tick intervals together span exactly 5·N selected strobes, and each of the two spans floor or ceil of 2.5·N strobes.
- R4: Word bits 6:0 hold the integer value N (2 to 127). With an integer predivide ratio P, ticks come every P·N selected strobes.
- R5: A predivide code of 0, or N below 2, produces no ticks while that word is active.
- R6: While en_i is low, tick_o and clk_o stay 0 and both divider counters are cleared. After en_i rises, the first tick completes on the P·N-th selected strobe.
- R7: A word loaded while running takes effect only at the next tick. The period in progress completes with the old setting, and the following periods use the new one.
- R8: tick_o is high for single cycles only, and clk_o changes level exactly on cycles where tick_o is high.
- R9: After reset, tick_o and clk_o are 0 and the active configuration is invalid. No tick occurs until a word is loaded.
- R10: Word bits 14:11 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_ref_stb_i | input | 1 | Reference source strobe |
| src_pll_a_stb_i | input | 1 | PLL A source strobe |
| src_pll_b_stb_i | input | 1 | PLL B source strobe |
| cfg_word_i | input | 15 | Control word: select bits, predivide code, integer value |
| cfg_load_i | input | 1 | One-cycle pulse that captures cfg_word_i as the pending word |
| en_i | input | 1 | Output enable level |
| tick_o | output | 1 | One-cycle tick at each completed division period |
| clk_o | output | 1 | Level that toggles on every tick |

## Verification
The bench uses the default parameters: a 7-bit integer field and a 2-bit predivide code. This lets it reach both ends of the integer range, from a 4-cycle period at ratio 2 with N=2 up to 381 cycles at ratio 3 with N=127. The reference strobe fires every cycle, PLL A every second cycle and PLL B every third cycle. Each source choice therefore shows up as a distinct period length. For the 2.5 mode, odd N values are used so that the alternating 7/8-style interval pairs appear. Mid-period reloads and enable drops are placed a few cycles after a tick, so the boundary behaviour can be observed.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;

    parameter int unsigned DIV_W   = 7;
    parameter int unsigned PRE_W   = 2;
    parameter int unsigned CFG_W   = 15;
    parameter int unsigned NUM_SRC = 3;
    parameter int unsigned DIV_MIN = 2;

    // field positions inside the control word
    localparam int unsigned PRE_LSB  = DIV_W;
    localparam int unsigned PLLB_BIT = DIV_W + PRE_W;
    localparam int unsigned USE_BIT  = PLLB_BIT + 1;
    localparam int unsigned USED_W   = USE_BIT + 1;

    typedef enum logic [1:0] {
        SRC_REF   = 2'd0,
        SRC_PLL_A = 2'd1,
        SRC_PLL_B = 2'd2
    } src_e;

    typedef struct packed {
        logic              use_pll;
        logic              pll_b;
        logic [PRE_W-1:0]  pre;
        logic [DIV_W-1:0]  div;
    } cfg_t;

endpackage

// File: rtl/fracdiv_src_sel.sv
module fracdiv_src_sel
    import fracdiv_pkg::*;
#(
    parameter int unsigned N_SRC = NUM_SRC
) (
    input  logic [N_SRC-1:0] stb_vec_i,
    input  src_e             sel_i,
    output logic             stb_o
);

    logic [N_SRC-1:0] gated;

    for (genvar g = 0; g < N_SRC; g++) begin : g_gate
        assign gated[g] = stb_vec_i[g] & (int'(sel_i) == g);
    end

    assign stb_o = |gated;

endmodule

// File: rtl/fracdiv_prediv.sv
module fracdiv_prediv
    import fracdiv_pkg::*;
#(
    parameter int unsigned CODE_W = PRE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              stb_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              pulse_o
);

    // accumulator counts in half-strobe units: each strobe adds 2,
    // a pulse is issued when it reaches twice the ratio (code + 3)
    localparam int unsigned ACC_W = CODE_W + 2;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] limit;

    always_comb begin
        st_d    = st_q;
        step    = st_q.acc + ACC_W'(2);
        limit   = ACC_W'(code_i) + ACC_W'(3);
        pulse_o = 1'b0;
        if (stb_i && (code_i != '0)) begin
            if (step >= limit) begin
                pulse_o    = 1'b1;
                st_d.acc   = step - limit;
            end else begin
                st_d.acc   = step;
            end
        end
        if (clr_i) begin
            st_d.acc = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fracdiv_intdiv.sv
module fracdiv_intdiv
    import fracdiv_pkg::*;
#(
    parameter int unsigned CNT_W = DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             wrap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } int_st_t;

    int_st_t st_d, st_q;
    logic [CNT_W:0] nxt;

    always_comb begin
        st_d   = st_q;
        nxt    = {1'b0, st_q.cnt} + (CNT_W+1)'(1);
        wrap_o = inc_i && (nxt >= {1'b0, limit_i});
        if (inc_i) begin
            st_d.cnt = wrap_o ? '0 : nxt[CNT_W-1:0];
        end
        if (clr_i) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fracdiv_clkgen.sv
module fracdiv_clkgen
    import fracdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_ref_stb_i,
    input  logic             src_pll_a_stb_i,
    input  logic             src_pll_b_stb_i,
    input  logic [CFG_W-1:0] cfg_word_i,
    input  logic             cfg_load_i,
    input  logic             en_i,
    output logic             tick_o,
    output logic             clk_o
);

    typedef struct packed {
        cfg_t act;
        cfg_t pend;
        logic pend_vld;
        logic tick;
        logic clk_out;
    } top_st_t;

    top_st_t st_d, st_q;

    cfg_t   word_cfg;
    src_e   src_sel;
    logic   sel_stb;
    logic   pre_pulse;
    logic   div_wrap;
    logic   act_ok;
    logic   fire;
    logic   adopt;
    logic   cnt_clr;
    logic   div_inc;
    logic   unused_rsvd;

    assign unused_rsvd = ^cfg_word_i[CFG_W-1:USED_W];

    // field extraction of the incoming word
    always_comb begin
        word_cfg.div     = cfg_word_i[DIV_W-1:0];
        word_cfg.pre     = cfg_word_i[PRE_LSB +: PRE_W];
        word_cfg.pll_b   = cfg_word_i[PLLB_BIT];
        word_cfg.use_pll = cfg_word_i[USE_BIT];
    end

    always_comb begin
        if (!st_q.act.use_pll)   src_sel = SRC_REF;
        else if (st_q.act.pll_b) src_sel = SRC_PLL_B;
        else                     src_sel = SRC_PLL_A;
    end

    fracdiv_src_sel #(.N_SRC(NUM_SRC)) u_src (
        .stb_vec_i ({src_pll_b_stb_i, src_pll_a_stb_i, src_ref_stb_i}),
        .sel_i     (src_sel),
        .stb_o     (sel_stb)
    );

    fracdiv_prediv #(.CODE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .stb_i   (sel_stb),
        .code_i  (st_q.act.pre),
        .pulse_o (pre_pulse)
    );

    fracdiv_intdiv #(.CNT_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .inc_i   (div_inc),
        .limit_i (st_q.act.div),
        .wrap_o  (div_wrap)
    );

    always_comb begin
        st_d    = st_q;
        act_ok  = (st_q.act.pre != '0) && (st_q.act.div >= DIV_W'(DIV_MIN));
        div_inc = en_i && act_ok && pre_pulse;
        fire    = div_inc && div_wrap;
        adopt   = st_q.pend_vld && (fire || !act_ok || !en_i);
        cnt_clr = !en_i || !act_ok || adopt;

        st_d.tick    = fire;
        st_d.clk_out = en_i ? (st_q.clk_out ^ fire) : 1'b0;

        if (adopt) begin
            st_d.act      = st_q.pend;
            st_d.pend_vld = 1'b0;
        end
        if (cfg_load_i) begin
            st_d.pend     = word_cfg;
            st_d.pend_vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;
    assign clk_o  = st_q.clk_out;

endmodule

// File: rtl/fracdiv_clkgen_chk.sv
module fracdiv_clkgen_chk
    import fracdiv_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic tick_o,
    input logic clk_o,
    input logic act_ok,
    input cfg_t act
);

    assert_tick_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    assert_clk_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (clk_o != $past(clk_o)));

    assert_clk_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && !tick_o) |-> $stable(clk_o));

    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!tick_o && !clk_o));

    assert_invalid_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !act_ok |=> !tick_o);

    assert_cfg_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act != $past(act)) |-> (tick_o || !$past(en_i) || !$past(act_ok)));

endmodule

bind fracdiv_clkgen fracdiv_clkgen_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .tick_o (tick_o),
    .clk_o  (clk_o),
    .act_ok (act_ok),
    .act    (st_q.act)
);

// File: tb/fracdiv_clkgen_tb.sv
module fracdiv_clkgen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_ref = 1'b1;
    logic        s_a = 1'b0;
    logic        s_b = 1'b0;
    logic [14:0] word = '0;
    logic        load = 1'b0;
    logic        en = 1'b0;
    logic        tick_o;
    logic        clk_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fracdiv_clkgen u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .src_ref_stb_i   (s_ref),
        .src_pll_a_stb_i (s_a),
        .src_pll_b_stb_i (s_b),
        .cfg_word_i      (word),
        .cfg_load_i      (load),
        .en_i            (en),
        .tick_o          (tick_o),
        .clk_o           (clk_o)
    );

    // strobes: ref every cycle, PLL A every 2nd, PLL B every 3rd
    initial begin
        int cyc;
        cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            s_a = (cyc % 2) == 0;
            s_b = (cyc % 3) == 0;
        end
    end

    function automatic logic [14:0] mk(input bit use_pll, input bit pll_b,
                                       input int pre, input int n);
        return {4'b0000, use_pll, pll_b, 2'(pre), 7'(n)};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts negedge samples until tick_o seen; 0 on timeout
    task automatic get_interval(output int iv);
        iv = 0;
        for (int k = 1; k <= 2000; k++) begin
            @(negedge clk);
            if (tick_o) begin
                iv = k;
                return;
            end
        end
    endtask

    task automatic load_cfg(input logic [14:0] w);
        @(negedge clk);
        word = w;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_en(input bit v);
        @(negedge clk);
        en = v;
    endtask

    task automatic quiet_for(input string req, input int n);
        int seen;
        seen = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (tick_o) seen++;
        end
        chk(req, seen, 0);
    endtask

    task automatic t_reset();
        chk("R9 tick after reset", int'(tick_o), 0);
        chk("R9 clk after reset", int'(clk_o), 0);
        set_en(1'b1);
        quiet_for("R9 no tick before any load", 60);
        set_en(1'b0);
    endtask

    task automatic run_int(input string req, input int pre, input int n, input int ratio);
        int iv;
        logic c0;
        set_en(1'b0);
        load_cfg(mk(1'b0, 1'b0, pre, n));
        set_en(1'b1);
        get_interval(iv);
        chk({req, " R6 first tick"}, iv, ratio * n);
        c0 = clk_o;
        @(negedge clk);
        chk("R8 tick single cycle", int'(tick_o), 0);
        get_interval(iv);
        chk({req, " R4 period"}, iv + 1, ratio * n);
        chk("R8 clk_o toggles per tick", int'(clk_o != c0), 1);
    endtask

    task automatic t_integer();
        run_int("R2 code1", 1, 2, 2);
        run_int("R2 code3", 3, 5, 3);
        run_int("R4 max", 3, 127, 3);
        run_int("R4 n9", 1, 9, 2);
        set_en(1'b0);
    endtask

    task automatic run_frac(input int n);
        int i1, i2, lo;
        set_en(1'b0);
        load_cfg(mk(1'b0, 1'b0, 2, n));
        set_en(1'b1);
        get_interval(i1);
        get_interval(i1);
        get_interval(i2);
        chk("R3 pair span", i1 + i2, 5 * n);
        lo = (5 * n) / 2;
        chk("R3 interval bounds", int'((i1 == lo || i1 == lo + (n % 2)) &&
                                       (i2 == lo || i2 == lo + (n % 2))), 1);
    endtask

    task automatic t_frac();
        run_frac(2);
        run_frac(3);
        run_frac(7);
        run_frac(4);
        set_en(1'b0);
    endtask

    task automatic run_src(input string req, input logic [14:0] w, input int exp);
        int iv;
        set_en(1'b0);
        load_cfg(w);
        set_en(1'b1);
        get_interval(iv);
        get_interval(iv);
        chk(req, iv, exp);
    endtask

    task automatic t_src();
        run_src("R1 ref", mk(1'b0, 1'b0, 1, 2), 4);
        run_src("R1 bit9 ignored on ref", mk(1'b0, 1'b1, 1, 2), 4);
        run_src("R1 pll A", mk(1'b1, 1'b0, 1, 2), 8);
        run_src("R1 pll B", mk(1'b1, 1'b1, 1, 2), 12);
        run_src("R10 upper bits ignored", 15'h7800 | mk(1'b0, 1'b0, 1, 2), 4);
        set_en(1'b0);
    endtask

    task automatic t_invalid();
        set_en(1'b0);
        load_cfg(mk(1'b0, 1'b0, 0, 5));
        set_en(1'b1);
        quiet_for("R5 code 0", 200);
        set_en(1'b0);
        load_cfg(mk(1'b0, 1'b0, 1, 1));
        set_en(1'b1);
        quiet_for("R5 n=1", 100);
        set_en(1'b0);
        load_cfg(mk(1'b0, 1'b0, 3, 0));
        set_en(1'b1);
        quiet_for("R5 n=0", 100);
        set_en(1'b0);
    endtask

    // sync to a tick, load w two samples later, return the interval
    task automatic reload_mid(input logic [14:0] w, output int iv);
        int k;
        get_interval(k);
        @(negedge clk);
        word = w;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        get_interval(k);
        iv = (k == 0) ? 0 : k + 2;
    endtask

    task automatic t_switch();
        int iv;
        set_en(1'b0);
        load_cfg(mk(1'b0, 1'b0, 1, 4));
        set_en(1'b1);
        reload_mid(mk(1'b0, 1'b0, 1, 2), iv);
        chk("R7 old period completes", iv, 8);
        get_interval(iv);
        chk("R7 new period", iv, 4);
        get_interval(iv);
        chk("R7 new period again", iv, 4);
        reload_mid(mk(1'b0, 1'b0, 0, 2), iv);
        chk("R7 period before invalid word", iv, 4);
        quiet_for("R7 invalid word after boundary", 100);
        set_en(1'b0);
    endtask

    task automatic t_disable();
        int iv;
        int bad;
        set_en(1'b0);
        load_cfg(mk(1'b0, 1'b0, 1, 4));
        set_en(1'b1);
        get_interval(iv);
        repeat (3) @(negedge clk);
        en = 1'b0;
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (tick_o || clk_o) bad++;
        end
        chk("R6 quiet and low while disabled", bad, 0);
        set_en(1'b1);
        get_interval(iv);
        chk("R6 full period after re-enable", iv, 8);
        set_en(1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_integer();
        t_frac();
        t_src();
        t_invalid();
        t_switch();
        t_disable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule